// File: doc/BRIEF.md
# Protected Memory Path with Fault-Injection Bypass

This block sits between a processor and a small data memory and protects every stored word with a single-error-correcting, double-error-detecting Hamming code. Each processor write stores the data word together with freshly computed check bits; each processor read recomputes them from the stored data, repairs any single flipped bit before the word is returned, and flags words with two flipped bits as unrepairable. It never silently miscorrects them.

A second, debug-side port shares the same storage. In protected mode it behaves exactly like the processor port. In raw mode it skips the code entirely. A raw read returns the complete stored codeword, check bits included and uncorrected. A raw write is a flip operation: the supplied mask is XOR-ed into the stored data bits while the check bits stay untouched. This lets a test campaign plant single or double upsets behind the code and then watch the protected path react. The mode is chosen per access. It is meant to be set when an experiment is prepared and to be used only on words the code protects.

Top module: `edac_mem_path`

## Requirements
- R1: A protected write stores the data with its check bits; a later protected read of that word returns the same data with both error pulses low.
- R2: When exactly one stored data bit differs from what was written, a processor read returns the originally written data and pulses `err_corr` for one cycle, together with `cpu_rvalid`.
- R3: When exactly two stored data bits are flipped, the read pulses `err_uncorr` with `err_corr` low and returns the stored data unchanged.
- R4: A raw debug read returns the stored codeword on `dbg_rdata`, with data in bits [31:0] and check bits in [38:32]. Check bit k (k = 0..5) is the parity of the data bits whose Hamming position has bit k set. Data bit i takes the i-th position, counting from 1 and skipping powers of two. Bit 38 is the parity of all 32 data bits and six check bits. No correction is applied and no error pulse is raised.
- R5: A raw debug write XORs `dbg_wdata` into the stored data bits of the addressed word and leaves every other data bit and all seven check bits unchanged.
- R6: A protected debug read corrects like the processor path, returning the data in `dbg_rdata[31:0]` with zeros above, and raises the same error pulses.
- R7: When both ports request in the same cycle, the processor access is performed and `dbg_gnt` stays low. A debug request with no processor request is granted in that cycle, so a held debug request is served in the next free cycle.
- R8: `corr_count` rises by exactly one for each corrected protected read and is otherwise unchanged.
- R9: Read data and its valid pulse appear one clock after the accepted read request; writes produce no valid pulse.
- R10: After reset all valid and error outputs are low, the counter is zero and every word reads as zero without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | DATA_W | Corrected processor read data |
| dbg_req | input | 1 | Debug access request, held until granted |
| dbg_we | input | 1 | Debug write (1) or read (0) |
| dbg_raw | input | 1 | Debug raw mode (1) or protected mode (0) |
| dbg_addr | input | ADDR_W | Debug word address |
| dbg_wdata | input | DATA_W | Write data, or flip mask in raw mode |
| dbg_gnt | output | 1 | Debug request accepted this cycle |
| dbg_rvalid | output | 1 | Debug read data valid |
| dbg_rdata | output | DATA_W+7 | Raw codeword or zero-extended corrected data |
| err_corr | output | 1 | Corrected-error pulse for a protected read |
| err_uncorr | output | 1 | Uncorrectable-error pulse for a protected read |
| corr_count | output | CNT_W | Number of corrected reads |

## Verification
The assertions check the port protocol on every cycle. They cover processor priority over debug, the one-cycle read latency of both ports, and the exclusivity of the two error pulses. They also check that pulses follow only protected reads and that the counter moves exactly with the corrected pulse. Whether a flagged word was really repaired, and whether a raw flip left the check bits intact, depends on the stored contents. Only the bench scenarios can show that. The bench plants flips in every data bit position and in pairs, then compares the returned words with its own encoder and brute-force decoder.

// File: rtl/edac_pkg.sv
package edac_pkg;

    localparam int MASK_MAX = 256;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_DBG  = 2'd2
    } src_e;

    function automatic bit is_pow2(int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // number of Hamming bits needed for dw data bits
    function automatic int hamming_bits(int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // Hamming position of data bit idx (positions skip powers of two)
    function automatic int data_pos(int idx);
        int seen;
        seen = 0;
        for (int p = 3; p < 2 * MASK_MAX; p++) begin
            if (!is_pow2(p)) begin
                if (seen == idx) return p;
                seen++;
            end
        end
        return 0;
    endfunction

    // data bits covered by Hamming bit b
    function automatic logic [MASK_MAX-1:0] cover_mask(int dw, int b);
        logic [MASK_MAX-1:0] m;
        m = '0;
        for (int i = 0; i < MASK_MAX; i++) begin
            if (i < dw && ((data_pos(i) >> b) & 1) == 1) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/edac_encoder.sv
module edac_encoder
    import edac_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int HB     = hamming_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    output logic [HB:0]       chk
);

    logic [HB-1:0] ham;

    for (genvar b = 0; b < HB; b++) begin : g_ham
        localparam logic [MASK_MAX-1:0] COVER = cover_mask(DATA_W, b);
        assign ham[b] = ^(data & COVER[DATA_W-1:0]);
    end

    // top bit: overall parity over data and Hamming bits
    assign chk = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/edac_decoder.sv
module edac_decoder
    import edac_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int HB     = hamming_bits(DATA_W),
    localparam int CHK_W  = HB + 1
) (
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    output logic [DATA_W-1:0] fix_data,
    output logic              corr,
    output logic              uncorr
);

    logic [CHK_W-1:0]  re_chk;
    logic [HB-1:0]     syn;
    logic              par_bad;
    logic [DATA_W-1:0] flip;
    logic              hit_data;
    logic              hit_chk;

    edac_encoder #(.DATA_W(DATA_W)) i_reenc (
        .data (rd_data),
        .chk  (re_chk)
    );

    assign syn     = re_chk[HB-1:0] ^ rd_chk[HB-1:0];
    assign par_bad = (^rd_data) ^ (^rd_chk);

    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        localparam int POS = data_pos(i);
        assign flip[i] = (syn == HB'(POS));
    end

    assign hit_data = |flip;
    assign hit_chk  = (syn == '0) || $onehot(syn);
    assign corr     = par_bad && (hit_data || hit_chk);
    assign uncorr   = (par_bad || (syn != '0)) && !corr;
    assign fix_data = corr ? (rd_data ^ flip) : rd_data;

endmodule

// File: rtl/edac_store.sv
module edac_store #(
    parameter  int ADDR_W = 4,
    parameter  int WORD_W = 39,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/edac_arbiter.sv
module edac_arbiter
    import edac_pkg::*;
(
    input  logic cpu_req,
    input  logic dbg_req,
    output src_e src,
    output logic dbg_gnt
);

    always_comb begin
        if (cpu_req)      src = SRC_CPU;
        else if (dbg_req) src = SRC_DBG;
        else              src = SRC_IDLE;
    end

    assign dbg_gnt = (src == SRC_DBG);

endmodule

// File: rtl/edac_mem_path.sv
module edac_mem_path
    import edac_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int ADDR_W = 4,
    parameter  int CNT_W  = 16,
    localparam int CHK_W  = hamming_bits(DATA_W) + 1,
    localparam int CW     = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dbg_req,
    input  logic              dbg_we,
    input  logic              dbg_raw,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic              dbg_gnt,
    output logic              dbg_rvalid,
    output logic [CW-1:0]     dbg_rdata,
    output logic              err_corr,
    output logic              err_uncorr,
    output logic [CNT_W-1:0]  corr_count
);

    typedef struct packed {
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
    } word_t;

    src_e              src;
    logic              acc_on;
    logic              acc_dbg;
    logic              acc_we;
    logic              acc_raw;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic              acc_rd;
    logic              acc_checked;

    word_t             stored;
    word_t             wr_word;
    logic [CW-1:0]     stored_bits;
    logic [CHK_W-1:0]  enc_chk;
    logic [DATA_W-1:0] dec_data;
    logic              dec_corr;
    logic              dec_uncorr;

    edac_arbiter i_arb (
        .cpu_req (cpu_req),
        .dbg_req (dbg_req),
        .src     (src),
        .dbg_gnt (dbg_gnt)
    );

    always_comb begin
        acc_on      = (src != SRC_IDLE);
        acc_dbg     = (src == SRC_DBG);
        acc_we      = acc_dbg ? dbg_we    : cpu_we;
        acc_addr    = acc_dbg ? dbg_addr  : cpu_addr;
        acc_wdata   = acc_dbg ? dbg_wdata : cpu_wdata;
        acc_raw     = acc_dbg && dbg_raw;
        acc_rd      = acc_on && !acc_we;
        acc_checked = acc_rd && !acc_raw;
    end

    edac_store #(.ADDR_W(ADDR_W), .WORD_W(CW)) i_store (
        .clk   (clk),
        .rst   (rst),
        .we    (acc_on && acc_we),
        .addr  (acc_addr),
        .wdata (wr_word),
        .rdata (stored_bits)
    );

    assign stored = word_t'(stored_bits);

    edac_encoder #(.DATA_W(DATA_W)) i_enc (
        .data (acc_wdata),
        .chk  (enc_chk)
    );

    edac_decoder #(.DATA_W(DATA_W)) i_dec (
        .rd_data  (stored.data),
        .rd_chk   (stored.chk),
        .fix_data (dec_data),
        .corr     (dec_corr),
        .uncorr   (dec_uncorr)
    );

    // raw write flips data bits in place and keeps stored check bits
    always_comb begin
        if (acc_raw) begin
            wr_word.chk  = stored.chk;
            wr_word.data = stored.data ^ acc_wdata;
        end else begin
            wr_word.chk  = enc_chk;
            wr_word.data = acc_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
            dbg_rvalid <= 1'b0;
            dbg_rdata  <= '0;
            err_corr   <= 1'b0;
            err_uncorr <= 1'b0;
            corr_count <= '0;
        end else begin
            cpu_rvalid <= acc_rd && !acc_dbg;
            dbg_rvalid <= acc_rd && acc_dbg;
            err_corr   <= acc_checked && dec_corr;
            err_uncorr <= acc_checked && dec_uncorr;
            if (acc_rd && !acc_dbg) cpu_rdata <= dec_data;
            if (acc_rd && acc_dbg) begin
                if (acc_raw) dbg_rdata <= stored_bits;
                else         dbg_rdata <= {{CHK_W{1'b0}}, dec_data};
            end
            if (acc_checked && dec_corr && (corr_count != '1))
                corr_count <= corr_count + 1'b1;
        end
    end

endmodule

// File: rtl/edac_mem_path_chk.sv
module edac_mem_path_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req,
    input logic             cpu_we,
    input logic             dbg_req,
    input logic             dbg_we,
    input logic             dbg_raw,
    input logic             dbg_gnt,
    input logic             cpu_rvalid,
    input logic             dbg_rvalid,
    input logic             err_corr,
    input logic             err_uncorr,
    input logic [CNT_W-1:0] corr_count
);

    AST_CPU_FIRST: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> !dbg_gnt); // R7

    AST_DBG_SERVED: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !cpu_req) |-> dbg_gnt); // R7

    AST_CPU_RD_LAT: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we) |=> cpu_rvalid); // R9

    AST_CPU_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !(cpu_req && !cpu_we) |=> !cpu_rvalid); // R9

    AST_DBG_RD_LAT: assert property (@(posedge clk) disable iff (rst)
        (dbg_gnt && !dbg_we) |=> dbg_rvalid); // R9

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(err_corr && err_uncorr)); // R3

    AST_ERR_ONLY_CHECKED: assert property (@(posedge clk) disable iff (rst)
        (err_corr || err_uncorr) |->
            $past((cpu_req && !cpu_we) || (dbg_gnt && !dbg_we && !dbg_raw))); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (err_corr && ($past(corr_count) != '1)) |->
            (corr_count == CNT_W'($past(corr_count) + 1'b1))); // R8

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !err_corr |-> $stable(corr_count)); // R8

endmodule

bind edac_mem_path edac_mem_path_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .dbg_req    (dbg_req),
    .dbg_we     (dbg_we),
    .dbg_raw    (dbg_raw),
    .dbg_gnt    (dbg_gnt),
    .cpu_rvalid (cpu_rvalid),
    .dbg_rvalid (dbg_rvalid),
    .err_corr   (err_corr),
    .err_uncorr (err_uncorr),
    .corr_count (corr_count)
);

// File: tb/test_edac_mem_path.sv
`timescale 1ns/1ps
module test_edac_mem_path;

    localparam int DW = 32;
    localparam int AW = 4;
    localparam int KW = 7;
    localparam int WW = DW + KW;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_rvalid;
    logic [DW-1:0] cpu_rdata;
    logic          dbg_req, dbg_we, dbg_raw;
    logic [AW-1:0] dbg_addr;
    logic [DW-1:0] dbg_wdata;
    logic          dbg_gnt, dbg_rvalid;
    logic [WW-1:0] dbg_rdata;
    logic          err_corr, err_uncorr;
    logic [15:0]   corr_count;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    edac_mem_path i_edac_mem_path (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_raw(dbg_raw), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_gnt(dbg_gnt), .dbg_rvalid(dbg_rvalid), .dbg_rdata(dbg_rdata),
        .err_corr(err_corr), .err_uncorr(err_uncorr), .corr_count(corr_count)
    );

    // ---------------- reference code from the requirement text ----------------
    function automatic logic [KW-1:0] tb_enc(logic [DW-1:0] d);
        int pos_q[$];
        logic [5:0] h;
        h = '0;
        for (int p = 1; pos_q.size() < DW; p++)
            if ((p & (p - 1)) != 0) pos_q.push_back(p);
        for (int i = 0; i < DW; i++)
            for (int b = 0; b < 6; b++)
                if (((pos_q[i] >> b) & 1) == 1) h[b] = h[b] ^ d[i];
        return {(^d) ^ (^h), h};
    endfunction

    // brute-force decode: search all single flips for a valid codeword
    function automatic void tb_dec(input logic [WW-1:0] w, output logic [DW-1:0] d,
                                   output logic c, output logic u);
        logic [DW-1:0] dat;
        logic [KW-1:0] ck;
        dat = w[DW-1:0];
        ck  = w[WW-1:DW];
        d = dat; c = 1'b0; u = 1'b0;
        if (tb_enc(dat) == ck) return;
        for (int i = 0; i < DW; i++)
            if (tb_enc(dat ^ (DW'(1) << i)) == ck) begin
                d = dat ^ (DW'(1) << i); c = 1'b1; return;
            end
        for (int j = 0; j < KW; j++)
            if (tb_enc(dat) == (ck ^ (KW'(1) << j))) begin
                c = 1'b1; return;
            end
        u = 1'b1;
    endfunction

    // ---------------- cycle model ----------------
    logic [WW-1:0] m_mem [16];
    logic          e_cpu_rvalid, e_dbg_rvalid, e_corr, e_uncorr;
    logic [DW-1:0] e_cpu_rdata;
    logic [WW-1:0] e_dbg_rdata;
    int            e_count;

    always @(posedge clk) begin
        logic          dsel, wr, rd, raw, chkd, c, u;
        logic [AW-1:0] a;
        logic [DW-1:0] wd, dd;
        logic [WW-1:0] cur;
        if (rst) begin
            for (int i = 0; i < 16; i++) m_mem[i] = '0;
            e_cpu_rvalid = 0; e_dbg_rvalid = 0; e_corr = 0; e_uncorr = 0;
            e_cpu_rdata = '0; e_dbg_rdata = '0; e_count = 0;
        end else begin
            dsel = dbg_req && !cpu_req;
            a    = cpu_req ? cpu_addr : dbg_addr;
            wd   = cpu_req ? cpu_wdata : dbg_wdata;
            wr   = cpu_req ? cpu_we : (dsel && dbg_we);
            rd   = cpu_req ? !cpu_we : (dsel && !dbg_we);
            raw  = dsel && dbg_raw;
            chkd = rd && !raw;
            cur  = m_mem[a];
            tb_dec(cur, dd, c, u);
            e_cpu_rvalid = cpu_req && !cpu_we;
            e_dbg_rvalid = dsel && !dbg_we;
            e_corr       = chkd && c;
            e_uncorr     = chkd && u;
            if (e_cpu_rvalid) e_cpu_rdata = dd;
            if (e_dbg_rvalid) e_dbg_rdata = raw ? cur : {7'b0, dd};
            if (e_corr) e_count++;
            if (wr) m_mem[a] = raw ? {cur[WW-1:DW], cur[DW-1:0] ^ wd} : {tb_enc(wd), wd};
        end
    end

    // ---------------- check helpers ----------------
    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R9 cpu_rvalid", 64'(cpu_rvalid), 64'(e_cpu_rvalid));
        chk("R2 cpu_rdata",  64'(cpu_rdata),  64'(e_cpu_rdata));
        chk("R9 dbg_rvalid", 64'(dbg_rvalid), 64'(e_dbg_rvalid));
        chk("R4 dbg_rdata",  64'(dbg_rdata),  64'(e_dbg_rdata));
        chk("R2 err_corr",   64'(err_corr),   64'(e_corr));
        chk("R3 err_uncorr", 64'(err_uncorr), 64'(e_uncorr));
        chk("R8 corr_count", 64'(corr_count), 64'(e_count));
    endtask

    // called at a negedge; returns at the next negedge with results visible
    task automatic cyc(logic c_req, logic c_we, logic [AW-1:0] ca, logic [DW-1:0] cd,
                       logic d_req, logic d_we, logic d_raw, logic [AW-1:0] da, logic [DW-1:0] dd);
        cpu_req = c_req; cpu_we = c_we; cpu_addr = ca; cpu_wdata = cd;
        dbg_req = d_req; dbg_we = d_we; dbg_raw = d_raw; dbg_addr = da; dbg_wdata = dd;
        #1;
        chk("R7 dbg_gnt", 64'(dbg_gnt), 64'(d_req && !c_req));
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic cpu_wr(logic [AW-1:0] a, logic [DW-1:0] d);
        cyc(1, 1, a, d, 0, 0, 0, 0, 0);
    endtask
    task automatic cpu_rd(logic [AW-1:0] a);
        cyc(1, 0, a, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic dbg_op(logic we, logic raw, logic [AW-1:0] a, logic [DW-1:0] d);
        cyc(0, 0, 0, 0, 1, we, raw, a, d);
    endtask

    initial begin
        #(8ns * 200000);
        bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] w1, w2, w4;
        w1 = 32'hA5A5_1234;
        w2 = 32'hDEAD_BEEF;
        w4 = 32'h1357_9BDF;
        rst = 1'b1;
        cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
        dbg_req = 0; dbg_we = 0; dbg_raw = 0; dbg_addr = 0; dbg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk("R10 cpu_rvalid", 64'(cpu_rvalid), 0);
        chk("R10 dbg_rvalid", 64'(dbg_rvalid), 0);
        chk("R10 errors", 64'({err_corr, err_uncorr}), 0);
        chk("R10 corr_count", 64'(corr_count), 0);
        cpu_rd(9);
        chk("R10 read zero", 64'(cpu_rdata), 0);
        chk("R10 no error", 64'({err_corr, err_uncorr}), 0);

        // R1 plain write and read
        cpu_wr(1, w1);
        cpu_wr(2, w2);
        cpu_rd(1);
        chk("R1 data", 64'(cpu_rdata), 64'(w1));
        chk("R1 no error", 64'({err_corr, err_uncorr}), 0);

        // R4 raw read returns codeword
        dbg_op(0, 1, 1, 0);
        chk("R4 codeword", 64'(dbg_rdata), 64'({tb_enc(w1), w1}));
        chk("R4 no flag", 64'({err_corr, err_uncorr}), 0);

        // R5 raw flip of one data bit keeps check bits
        dbg_op(1, 1, 1, 32'h0000_0080);
        dbg_op(0, 1, 1, 0);
        chk("R5 flipped word", 64'(dbg_rdata), 64'({tb_enc(w1), w1 ^ 32'h80}));

        // R2 correction on processor read
        cpu_rd(1);
        chk("R2 corrected", 64'(cpu_rdata), 64'(w1));
        chk("R2 pulse", 64'(err_corr), 1);
        chk("R8 count one", 64'(corr_count), 1);
        idle();
        chk("R2 pulse ends", 64'(err_corr), 0);

        // R3 double flip detected, not corrected
        dbg_op(1, 1, 2, 32'h8000_0001);
        cpu_rd(2);
        chk("R3 uncorr", 64'(err_uncorr), 1);
        chk("R3 no corr", 64'(err_corr), 0);
        chk("R3 data as stored", 64'(cpu_rdata), 64'(w2 ^ 32'h8000_0001));
        chk("R8 unchanged", 64'(corr_count), 1);

        // R6 protected debug read corrects
        dbg_op(0, 0, 1, 0);
        chk("R6 debug corrected", 64'(dbg_rdata), 64'({7'b0, w1}));
        chk("R6 pulse", 64'(err_corr), 1);
        chk("R8 count two", 64'(corr_count), 2);

        // R7 collision: processor first, debug next cycle
        cyc(1, 0, 2, 0, 1, 1, 0, 3, 32'h0BAD_F00D);
        chk("R7 cpu served", 64'(cpu_rvalid), 1);
        cyc(0, 0, 0, 0, 1, 1, 0, 3, 32'h0BAD_F00D);
        cpu_rd(3);
        chk("R7 debug write landed", 64'(cpu_rdata), 64'(32'h0BAD_F00D));
        chk("R1 clean after debug write", 64'({err_corr, err_uncorr}), 0);

        // R2 every data bit position
        cpu_wr(4, w4);
        for (int b = 0; b < DW; b++) begin
            dbg_op(1, 1, 4, DW'(1) << b);
            cpu_rd(4);
            chk("R2 bit sweep", 64'(cpu_rdata), 64'(w4));
            dbg_op(1, 1, 4, DW'(1) << b);
        end
        dbg_op(0, 1, 4, 0);
        chk("R5 restored", 64'(dbg_rdata), 64'({tb_enc(w4), w4}));
        chk("R8 final count", 64'(corr_count), 64'(2 + DW));
        idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule